// File: doc/BRIEF.md
# Register-Exchange Survivor Memory with State Purging

This block holds the survivor paths of a 64-state trellis decoder using register exchange, in a decoder that may prune any state in any step. Each accepted step brings three things for every state: the index of the state it came from, the newly decoded symbol, and an active flag. Every active state takes over its predecessor's survivor, shifted by one entry, with the new symbol appended. A purged state keeps its register unchanged, as a clock-gated array would.

No state is sure to remain active under pruning, so the output cannot come from a fixed state. The block therefore picks the lowest-numbered active state from the flags of the last accepted step. It uses a three-level tree of 4-to-2 priority encoders, and it outputs the oldest entry of that state's survivor. A flag reports the case where every state was purged. A valid signal tells the consumer when the survivor registers have been filled.

Top module: `surv_re_purge`

## Requirements
- R1: After reset, `dec_valid` is 0, `sel_state` is 0, `none_active` is 0 and `dec_out` is 0. All survivors are cleared, and every state counts as active until the first accepted step.
- R2: On a step with `step_valid` high, each state s whose flag `active_flags[s]` is 1 loads the survivor of state `pred_idx[6*s+5:6*s]` as it was before the step. That survivor is shifted one entry toward the oldest end, and `sym_in[s]` goes in as the newest entry.
- R3: On a step, each state whose flag is 0 (purged) keeps its survivor unchanged.
- R4: While `step_valid` is low, no survivor, no captured flag and no step count changes, whatever the other inputs do.
- R5: An accepted step captures `active_flags`. State selection always uses the flags captured at the most recent accepted step.
- R6: `sel_state` is the lowest index whose captured flag is 1. The encoders give flag bit 0 the highest priority.
- R7: If all captured flags are 0, `sel_state` is 0 and `none_active` is 1. Otherwise `none_active` is 0.
- R8: `dec_valid` is 0 until exactly 42 steps have been accepted since reset. From then on it is 1.
- R9: `dec_out` is the oldest of the 42 entries in the survivor of state `sel_state`, i.e. the symbol appended 42 steps earlier along that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | Accept one trellis step this cycle |
| active_flags | input | 64 | Per-state flag, 1 = active, 0 = purged |
| pred_idx | input | 384 | Predecessor index for each state, 6 bits per state, state s at bits [6s+5:6s] |
| sym_in | input | 64 | Decoded symbol for each state, state s at bit s |
| dec_out | output | 1 | Oldest survivor entry of the selected state |
| dec_valid | output | 1 | Survivors have been filled with 42 steps |
| sel_state | output | 6 | Lowest-indexed active state from the captured flags |
| none_active | output | 1 | All captured flags are zero |

## Verification
The survivor update and the change of output state both take effect on the same accepted step. The selected index moves to a new state while that state's register is being rewritten from a different predecessor. The bench drives every step with new pseudo-random predecessors, symbols and sparse flag patterns, so the selected state and the path it inherits change together. It compares `dec_out` after each step with the oldest entry of an independent survivor model, indexed by the lowest set flag. The step on which `dec_valid` first rises is also a step with a fresh selection, and the bench checks both on that exact step.

// File: rtl/surv_re_purge.sv
module surv_re_purge #(
  parameter int SURV_LEN = 42,
  parameter int SYM_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_valid,
  input  logic [63:0]         active_flags,
  input  logic [64*6-1:0]     pred_idx,
  input  logic [64*SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0]    dec_out,
  output logic                dec_valid,
  output logic [5:0]          sel_state,
  output logic                none_active
);
  localparam int NS = 64;
  localparam int IW = 6;
  localparam int SW = SURV_LEN * SYM_W;
  localparam int CW = $clog2(SURV_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(SURV_LEN);

  logic [SW-1:0] surv [NS];
  logic [NS-1:0] flags_q;
  logic [CW-1:0] cnt;

  function automatic logic [1:0] pe4(input logic [3:0] v);
    if (v[0])      return 2'd0;
    else if (v[1]) return 2'd1;
    else if (v[2]) return 2'd2;
    else if (v[3]) return 2'd3;
    else           return 2'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) surv[s] <= '0;
      flags_q <= '1;
      cnt     <= '0;
    end else if (step_valid) begin
      flags_q <= active_flags;
      if (cnt != FULL) cnt <= cnt + CW'(1);
      for (int s = 0; s < NS; s++)
        if (active_flags[s])
          surv[s] <= {surv[pred_idx[s*IW +: IW]][SW-SYM_W-1:0], sym_in[s*SYM_W +: SYM_W]};
    end
  end

  logic [3:0]  grp_any, quad_any, quad_sel;
  logic [15:0] grp_sel;
  logic [1:0]  idx_hi, idx_mid, idx_lo;

  for (genvar g = 0; g < 4; g++) begin : g_grp
    assign grp_any[g]  = |flags_q[g*16 +: 16];
    assign quad_any[g] = |grp_sel[g*4 +: 4];
  end

  assign idx_hi      = pe4(grp_any);
  assign grp_sel     = flags_q[{idx_hi, 4'b0000} +: 16];
  assign idx_mid     = pe4(quad_any);
  assign quad_sel    = grp_sel[{idx_mid, 2'b00} +: 4];
  assign idx_lo      = pe4(quad_sel);
  assign sel_state   = {idx_hi, idx_mid, idx_lo};
  assign none_active = ~|grp_any;
  assign dec_out     = surv[sel_state][SW-1 -: SYM_W];
  assign dec_valid   = (cnt == FULL);

  assert_sel_is_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !none_active |-> flags_q[sel_state]);
  assert_sel_is_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !none_active |-> ((flags_q & ((64'd1 << sel_state) - 64'd1)) == 64'd0));
  assert_empty_gives_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    none_active |-> (sel_state == 6'd0 && flags_q == 64'd0));
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(flags_q) && $stable(cnt) && $stable(dec_out)));
  assert_capture_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> (flags_q == $past(active_flags)));
  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_valid);
  assert_valid_needs_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(step_valid));

  for (genvar k = 0; k < NS; k++) begin : g_chk
    assert_purged_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !active_flags[k]) |=> $stable(surv[k]));
  end
endmodule

// File: tb/tb_surv_re_purge.sv
module tb_surv_re_purge;
  localparam int L = 42;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_valid = 1'b0;
  logic [63:0]  active_flags = '0;
  logic [383:0] pred_idx = '0;
  logic [63:0]  sym_in = '0;
  logic         dec_out, dec_valid, none_active;
  logic [5:0]   sel_state;

  int checks = 0;
  int failures = 0;
  int nsteps = 0;
  logic [L-1:0] ms [64];
  logic [63:0]  cur_flags = '1;
  logic [63:0]  rs = 64'h9E37_79B9_7F4A_7C15;

  surv_re_purge dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .active_flags(active_flags),
    .pred_idx(pred_idx), .sym_in(sym_in), .dec_out(dec_out), .dec_valid(dec_valid),
    .sel_state(sel_state), .none_active(none_active));

  always #10 clk = ~clk;

  // {flags, expected sel_state, expected none_active}
  localparam logic [70:0] VEC [9] = '{
    {64'h0000_0000_0000_0001, 6'd0,  1'b0},
    {64'h8000_0000_0000_0000, 6'd63, 1'b0},
    {64'h0000_0000_0000_00F0, 6'd4,  1'b0},
    {64'h0000_0000_0000_0000, 6'd0,  1'b1},
    {64'h0001_0000_0000_0000, 6'd48, 1'b0},
    {64'h0000_0000_0002_0000, 6'd17, 1'b0},
    {64'h0100_0000_8000_0000, 6'd31, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 6'd1,  1'b0},
    {64'h0000_0800_0000_0000, 6'd43, 1'b0}
  };

  function automatic logic [63:0] nxt(input logic [63:0] v);
    logic [63:0] x = v;
    x ^= x << 13;
    x ^= x >> 7;
    x ^= x << 17;
    return x;
  endfunction

  function automatic logic [5:0] lowest(input logic [63:0] f);
    for (int i = 0; i < 64; i++) if (f[i]) return 6'(i);
    return 6'd0;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_step(input logic [63:0] f);
    logic [L-1:0] nx [64];
    @(negedge clk);
    for (int s = 0; s < 64; s++) begin
      rs = nxt(rs);
      pred_idx[s*6 +: 6] = rs[5:0];
      sym_in[s] = rs[40];
    end
    active_flags = f;
    step_valid = 1'b1;
    for (int s = 0; s < 64; s++)
      nx[s] = f[s] ? {ms[pred_idx[s*6 +: 6]][L-2:0], sym_in[s]} : ms[s];
    for (int s = 0; s < 64; s++) ms[s] = nx[s];
    cur_flags = f;
    @(posedge clk);
    nsteps++;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic check_outputs();
    logic [5:0] es = lowest(cur_flags);
    chk(sel_state == es, "R6 sel_state lowest active", sel_state, es);
    chk(none_active == (cur_flags == 0), "R7 none_active", none_active, cur_flags == 0);
    chk(dec_out == ms[es][L-1], "R2 R3 R9 dec_out oldest entry", dec_out, ms[es][L-1]);
    chk(dec_valid == (nsteps >= L), "R8 dec_valid timing", dec_valid, nsteps >= L);
  endtask

  initial begin
    #4_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] hs;
    logic ho, hv, hn;
    for (int s = 0; s < 64; s++) ms[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1 reset dec_valid", dec_valid, 0);
    chk(sel_state == 6'd0, "R1 reset sel_state", sel_state, 0);
    chk(none_active == 1'b0, "R1 reset none_active", none_active, 0);
    chk(dec_out == 1'b0, "R1 reset dec_out", dec_out, 0);

    for (int v = 0; v < 9; v++) begin
      do_step(VEC[v][70:7]);
      chk(sel_state == VEC[v][6:1], "R6 R5 table sel_state", sel_state, VEC[v][6:1]);
      chk(none_active == VEC[v][0], "R7 table none_active", none_active, VEC[v][0]);
      check_outputs();
    end

    for (int t = 0; t < 90; t++) begin
      logic [63:0] a, b, c;
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = rs;
      rs = nxt(rs); c = rs;
      if (t % 17 == 5) do_step(64'd0);
      else if (t % 3 == 0) do_step(a | b);
      else do_step(a & b & c);
      check_outputs();
      if (t == 20 || t == 31 || t == 60) begin
        hs = sel_state; ho = dec_out; hv = dec_valid; hn = none_active;
        for (int s = 0; s < 64; s++) begin
          rs = nxt(rs);
          pred_idx[s*6 +: 6] = rs[5:0];
          sym_in[s] = rs[41];
        end
        active_flags = ~active_flags;
        repeat (4) @(negedge clk);
        chk(sel_state == hs, "R4 idle sel_state held", sel_state, hs);
        chk(dec_out == ho, "R4 idle dec_out held", dec_out, ho);
        chk(dec_valid == hv, "R4 idle dec_valid held", dec_valid, hv);
        chk(none_active == hn, "R4 idle none_active held", none_active, hn);
        check_outputs();
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1 re-reset dec_valid", dec_valid, 0);
    chk(sel_state == 6'd0 && none_active == 1'b0, "R1 re-reset selection", sel_state, 0);
    chk(dec_out == 1'b0, "R1 re-reset dec_out", dec_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule